// File: doc/BRIEF.md
# Two-Lane Byte-Write and Read-Return Datapath

This block is the data half of a synchronous burst memory. Each clock edge it takes an address chosen by an external sequencer together with a set of active-low write controls. It turns these into one write strobe per byte lane and updates a small internal word array. Each lane is nine bits wide by default: eight data bits plus a parity bit, and the parity bit is stored and returned exactly like the data bits.

Read data comes back in one of two ways. The pipelined mode adds an output register. The flow-through mode passes the array contents straight out after the address register. An asynchronous active-low output enable gates the drive-enable output. The data pins are modelled as a value plus a drive enable, so the tri-state buffer itself stays outside this block.

Lane enables are masked on an edge where the processor-start strobe is low. On any other selected edge, a sampled low lane enable turns the outputs off for the following cycle.

Top module: `bwd_datapath`

## Requirements
- R1: On a selected edge with `wr_all_n` low, every lane of the word at `addr` takes `wdata`, whatever `wr_sel_n` and `lane_wr_n` are.
- R2: With `wr_all_n` high, lane n (lane n is bits n*9+8 down to n*9) is written only when `wr_sel_n` is low and `lane_wr_n[n]` is low. Other lanes keep their contents.
- R3: With `wr_all_n` high and either `wr_sel_n` high or both lane enables high, the edge is a read, and the addressed word is left unchanged.
- R4: On a selected edge with `pstart_n` low, `lane_wr_n` is ignored. No lane is written unless `wr_all_n` is low, and the edge is treated as a read whose data is driven.
- R5: A lane enable sampled low on a selected edge with `pstart_n` high forces `dq_oe` low for the whole following cycle, even with `oe_n` low and read data pending.
- R6: With `flow_mode` low (pipelined), a read whose address is taken on edge k is driven on `dq` after edge k+1, and not after edge k.
- R7: With `flow_mode` high (flow-through), a read taken on edge k is driven on `dq` after edge k.
- R8: `oe_n` high drops `dq_oe` at once, without waiting for a clock edge, and `oe_n` low restores it.
- R9: An edge with `acc_en` low turns the outputs off after that edge in flow-through mode, and one edge later in pipelined mode, once the pending read has been driven.
- R10: While `rst_n` is low, `dq_oe` is low.
- R11: All nine bits of each lane, including the parity bit (bit 8 of lane 0, bit 17 of lane 1), are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe_n` and `flow_mode` are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output stages |
| acc_en | input | 1 | Access selected on this edge; low is a deselect |
| pstart_n | input | 1 | Low on the edge where a processor-started access begins |
| addr | input | 6 | Word address from the sequencer |
| wr_all_n | input | 1 | Global write, active low, highest priority |
| wr_sel_n | input | 1 | Byte-write select, active low |
| lane_wr_n | input | 2 | Per-lane write enables, active low |
| wdata | input | 18 | Write data, two lanes of nine bits |
| flow_mode | input | 1 | 1 = flow-through, 0 = pipelined |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | output | 18 | Read data |
| dq_oe | output | 1 | High when `dq` is driven |

## Verification
The properties assume that `flow_mode` is static during traffic and only changes after at least two deselected edges. They also assume that `oe_n` and the write controls are steady around each rising edge. The stimulus drives every synchronous input two nanoseconds after a rising edge and samples the outputs at the same point. It switches the read mode only inside runs of idle edges, so no pending read ever crosses a mode change. The `oe_n` checks happen between edges, so the asynchronous gating is observed with no clock in between.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  // first output stage: read pending, outputs forced off
  typedef struct packed {
    logic vld;
    logic hiz;
  } stage1_t;
endpackage

// File: rtl/bwd_decode.sv
module bwd_decode #(
  parameter int LANES = 2
) (
  input  logic             acc_en,
  input  logic             pstart_n,
  input  logic             wr_all_n,
  input  logic             wr_sel_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] we_lane,
  output logic             rd_cycle,
  output logic             lane_low
);
  logic [LANES-1:0] lane_seen;

  // lane enables are masked on a processor-start edge
  assign lane_seen = pstart_n ? ~lane_wr_n : '0;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    always_comb begin
      if (!acc_en)        we_lane[n] = 1'b0;
      else if (!wr_all_n) we_lane[n] = 1'b1;
      else if (!wr_sel_n) we_lane[n] = lane_seen[n];
      else                we_lane[n] = 1'b0;
    end
  end

  assign rd_cycle = acc_en && (we_lane == '0);
  assign lane_low = acc_en && (|lane_seen);
endmodule

// File: rtl/bwd_array.sv
module bwd_array #(
  parameter int LANES     = 2,
  parameter int LANE_BITS = 9,
  parameter int DEPTH     = 64,
  localparam int W  = LANES * LANE_BITS,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [LANES-1:0] we_lane,
  input  logic [AW-1:0]    waddr,
  input  logic [W-1:0]     wdata,
  input  logic [AW-1:0]    raddr,
  output logic [W-1:0]     rdata
);
  for (genvar n = 0; n < LANES; n++) begin : g_bank
    logic [LANE_BITS-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_lane[n]) mem[waddr] <= wdata[n*LANE_BITS +: LANE_BITS];
    end

    assign rdata[n*LANE_BITS +: LANE_BITS] = mem[raddr];
  end
endmodule

// File: rtl/bwd_outpath.sv
module bwd_outpath import bwd_pkg::*; #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_cycle,
  input  logic         lane_low,
  input  logic         flow_mode,
  input  logic         oe_n,
  input  logic [W-1:0] arr_data,
  output logic [W-1:0] dq,
  output logic         dq_oe
);
  stage1_t      s1;
  logic         s2_vld;
  logic [W-1:0] s2_dat;
  logic         src_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= '0;
      s2_vld <= 1'b0;
    end else begin
      s1.vld <= rd_cycle;
      s1.hiz <= lane_low;
      s2_vld <= s1.vld;
    end
  end

  always_ff @(posedge clk) s2_dat <= arr_data;

  assign src_vld = flow_mode ? s1.vld : s2_vld;
  assign dq      = flow_mode ? arr_data : s2_dat;
  assign dq_oe   = !oe_n && src_vld && !s1.hiz;
endmodule

// File: rtl/bwd_datapath.sv
module bwd_datapath #(
  parameter int LANES     = 2,
  parameter int LANE_BITS = 9,
  parameter int DEPTH     = 64,
  localparam int W  = LANES * LANE_BITS,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             pstart_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_all_n,
  input  logic             wr_sel_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [W-1:0]     wdata,
  input  logic             flow_mode,
  input  logic             oe_n,
  output logic [W-1:0]     dq,
  output logic             dq_oe
);
  logic [LANES-1:0] we_lane;
  logic             rd_cycle;
  logic             lane_low;
  logic [AW-1:0]    addr_q;
  logic [W-1:0]     arr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (acc_en) addr_q <= addr;
  end

  bwd_decode #(.LANES(LANES)) u_dec (
    .acc_en(acc_en), .pstart_n(pstart_n), .wr_all_n(wr_all_n),
    .wr_sel_n(wr_sel_n), .lane_wr_n(lane_wr_n), .we_lane(we_lane),
    .rd_cycle(rd_cycle), .lane_low(lane_low)
  );

  bwd_array #(.LANES(LANES), .LANE_BITS(LANE_BITS), .DEPTH(DEPTH)) u_arr (
    .clk(clk), .we_lane(we_lane), .waddr(addr), .wdata(wdata),
    .raddr(addr_q), .rdata(arr_data)
  );

  bwd_outpath #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_cycle(rd_cycle), .lane_low(lane_low),
    .flow_mode(flow_mode), .oe_n(oe_n), .arr_data(arr_data),
    .dq(dq), .dq_oe(dq_oe)
  );
endmodule

// File: rtl/bwd_datapath_chk.sv
module bwd_datapath_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_en,
  input logic             pstart_n,
  input logic             wr_all_n,
  input logic             wr_sel_n,
  input logic [LANES-1:0] lane_wr_n,
  input logic             flow_mode,
  input logic             oe_n,
  input logic             dq_oe,
  input logic [LANES-1:0] we_lane
);
  // R1
  all_lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !wr_all_n) |-> (we_lane == {LANES{1'b1}}));

  // R2
  byte_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_all_n && wr_sel_n) |-> (we_lane == '0));

  // R4
  pstart_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstart_n && wr_all_n) |-> (we_lane == '0));

  // R5
  lane_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && pstart_n && (lane_wr_n != {LANES{1'b1}})) |=> !dq_oe);

  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  // R9
  flow_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && !acc_en) |=> !dq_oe);

  // R9
  pipe_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && !acc_en) ##1 (!flow_mode && !acc_en) |=> !dq_oe);

  // R10
  reset_off_chk: assert property (@(posedge clk)
    !rst_n |=> !dq_oe);
endmodule

bind bwd_datapath bwd_datapath_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .pstart_n(pstart_n),
  .wr_all_n(wr_all_n), .wr_sel_n(wr_sel_n), .lane_wr_n(lane_wr_n),
  .flow_mode(flow_mode), .oe_n(oe_n), .dq_oe(dq_oe), .we_lane(we_lane)
);

// File: tb/sim_bwd_datapath.sv
`timescale 1ns/1ps
module sim_bwd_datapath;
  localparam int W  = 18;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_en = 1'b0;
  logic          pstart_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_all_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [1:0]    lane_wr_n = 2'b11;
  logic [W-1:0]  wdata = '0;
  logic          flow_mode = 1'b0;
  logic          oe_n = 1'b0;
  logic [W-1:0]  dq;
  logic          dq_oe;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bwd_datapath u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .pstart_n(pstart_n),
    .addr(addr), .wr_all_n(wr_all_n), .wr_sel_n(wr_sel_n),
    .lane_wr_n(lane_wr_n), .wdata(wdata), .flow_mode(flow_mode),
    .oe_n(oe_n), .dq(dq), .dq_oe(dq_oe)
  );

  // drive one edge, then sample 2 ns after it
  task automatic step(input logic a, input logic ps, input logic [AW-1:0] ad,
                      input logic ga, input logic bs, input logic [1:0] ln,
                      input logic [W-1:0] d);
    acc_en = a; pstart_n = ps; addr = ad; wr_all_n = ga;
    wr_sel_n = bs; lane_wr_n = ln; wdata = d;
    @(posedge clk); #2;
  endtask

  task automatic idle();
    step(1'b0, 1'b1, '0, 1'b1, 1'b1, 2'b11, '0);
  endtask

  task automatic chk_oe(input string req, input logic exp);
    n_chk++;
    if (dq_oe !== exp) begin
      n_fail++;
      $display("FAIL %s dq_oe actual=%b expected=%b", req, dq_oe, exp);
    end
  endtask

  task automatic chk_dq(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (dq_oe !== 1'b1 || dq !== exp) begin
      n_fail++;
      $display("FAIL %s dq actual=%h (oe=%b) expected=%h", req, dq, dq_oe, exp);
    end
  endtask

  task automatic set_mode(input logic f);
    idle(); idle();
    flow_mode = f;
    idle(); idle();
  endtask

  task automatic t_reset();
    flow_mode = 1'b1; oe_n = 1'b0;
    step(1'b1, 1'b1, 6'd1, 1'b1, 1'b1, 2'b11, '0);
    step(1'b1, 1'b1, 6'd1, 1'b1, 1'b1, 2'b11, '0);
    chk_oe("R10", 1'b0);
    rst_n = 1'b1;
    idle(); idle();
  endtask

  task automatic t_global();
    set_mode(1'b0);
    step(1'b1, 1'b1, 6'd3, 1'b0, 1'b1, 2'b11, 18'h3A5A5);
    step(1'b1, 1'b1, 6'd4, 1'b0, 1'b0, 2'b01, 18'h15555);
    idle(); idle();
    step(1'b1, 1'b1, 6'd3, 1'b1, 1'b1, 2'b11, '0);
    chk_oe("R6", 1'b0);
    idle();
    chk_dq("R1_R11", 18'h3A5A5);
    idle();
    chk_oe("R9", 1'b0);
    step(1'b1, 1'b1, 6'd4, 1'b1, 1'b1, 2'b11, '0);
    idle();
    chk_dq("R1", 18'h15555);
    idle();
  endtask

  task automatic t_byte();
    set_mode(1'b1);
    step(1'b1, 1'b1, 6'd5, 1'b0, 1'b1, 2'b11, 18'h3FFFF);
    step(1'b1, 1'b1, 6'd5, 1'b1, 1'b0, 2'b10, 18'h00000);
    step(1'b1, 1'b1, 6'd5, 1'b1, 1'b1, 2'b00, 18'h00000);
    idle();
    step(1'b1, 1'b1, 6'd5, 1'b1, 1'b1, 2'b11, '0);
    chk_dq("R2_R3", 18'h3FE00);
    step(1'b1, 1'b1, 6'd5, 1'b1, 1'b0, 2'b11, 18'h00000);
    chk_dq("R3", 18'h3FE00);
    step(1'b1, 1'b1, 6'd8, 1'b0, 1'b1, 2'b11, 18'h3FFFF);
    step(1'b1, 1'b1, 6'd8, 1'b1, 1'b0, 2'b01, 18'h00000);
    idle();
    step(1'b1, 1'b1, 6'd8, 1'b1, 1'b1, 2'b11, '0);
    chk_dq("R2", 18'h001FF);
    idle();
  endtask

  task automatic t_pstart();
    step(1'b1, 1'b1, 6'd6, 1'b0, 1'b1, 2'b11, 18'h12345);
    idle();
    step(1'b1, 1'b0, 6'd6, 1'b1, 1'b0, 2'b00, 18'h00000);
    chk_dq("R4", 18'h12345);
    step(1'b1, 1'b1, 6'd6, 1'b1, 1'b1, 2'b11, '0);
    chk_dq("R4", 18'h12345);
    idle();
  endtask

  task automatic t_hiz();
    set_mode(1'b0);
    step(1'b1, 1'b1, 6'd6, 1'b1, 1'b1, 2'b11, '0);
    step(1'b1, 1'b1, 6'd7, 1'b1, 1'b0, 2'b01, 18'h3FFFF);
    chk_oe("R5", 1'b0);
    set_mode(1'b1);
    step(1'b1, 1'b1, 6'd6, 1'b1, 1'b1, 2'b00, '0);
    chk_oe("R5", 1'b0);
    idle();
  endtask

  task automatic t_oe();
    step(1'b1, 1'b1, 6'd6, 1'b1, 1'b1, 2'b11, '0);
    chk_dq("R8", 18'h12345);
    oe_n = 1'b1; #1;
    chk_oe("R8", 1'b0);
    oe_n = 1'b0; #1;
    chk_oe("R8", 1'b1);
    idle();
  endtask

  task automatic t_flow();
    step(1'b1, 1'b1, 6'd3, 1'b1, 1'b1, 2'b11, '0);
    chk_dq("R7", 18'h3A5A5);
    idle();
    chk_oe("R9", 1'b0);
  endtask

  task automatic t_pipe_burst();
    set_mode(1'b0);
    step(1'b1, 1'b1, 6'd3, 1'b1, 1'b1, 2'b11, '0);
    chk_oe("R6", 1'b0);
    step(1'b1, 1'b1, 6'd4, 1'b1, 1'b1, 2'b11, '0);
    chk_dq("R6", 18'h3A5A5);
    idle();
    chk_dq("R6", 18'h15555);
    idle();
    chk_oe("R9", 1'b0);
  endtask

  initial begin
    #2;
    t_reset();
    t_global();
    t_byte();
    t_pstart();
    t_hiz();
    t_oe();
    t_flow();
    t_pipe_burst();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule